// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends one command byte from a host controller to a PS/2 keyboard or mouse. The byte comes in on a valid/ready stream port. The block drives the two shared lines only through open-drain enables. An enable at 1 pulls its line low. An enable at 0 releases the line, and the external pull-up lets it float high. The block first claims the bus by holding the clock line low for a programmable number of cycles. It then places the start bit and hands the clock back to the device. On the device's clock it sends eight data bits and an odd parity bit. Last, it releases the data line and waits for the device to acknowledge.

The `busy` output is high from the cycle after a byte is accepted until the frame finishes. A neighbouring PS/2 receiver uses it to ignore line activity while a transmission is in progress. `done` pulses when the device has acknowledged the frame. `err` pulses when the device stops responding. Both line inputs pass through a synchroniser before any decision is made on them.

The command port follows these back-pressure rules:

- `cmd_ready` is high only while the block is idle.
- A byte is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high.
- While `cmd_valid` is high and `cmd_ready` is low, the block ignores `cmd_data` and the presenter must hold it.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `cmd_ready` is 1, `busy` is 0, and both drive enables are 0 (released).
- R2: A byte is accepted only on an edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is 0 while a frame is in progress, and a byte offered during that time does not affect the frame being sent.
- R3: After acceptance, the clock enable is 1 for exactly HOLD_CYCLES cycles while the data enable stays 0. After that hold, the data enable goes to 1 (start bit).
- R4: The start bit is driven with the clock still held low for exactly one cycle. The block then releases the clock, and the data line stays low until the device first pulls the clock low.
- R5: Data bits leave least significant bit first. Each bit is placed on the data line after the synchronised clock is seen low, and it is held unchanged while the clock is high. Line level equals bit value.
- R6: After the eight data bits, a ninth bit is sent that makes the number of ones across the nine bits odd.
- R7: On the clock low that follows the parity bit, the block releases the data line, so the device samples a high stop bit.
- R8: `done` is a one-cycle pulse. It appears only after the device has pulled data low and then pulled clock low. In the cycle `done` is high, `busy` is 0 and `cmd_ready` is 1, so a new byte can be accepted in that same cycle.
- R9: `busy` is 1 from the cycle after acceptance until the cycle in which `done` or `err` pulses.
- R10: If any wait on the device lasts TIMEOUT_CYCLES cycles (when that parameter is nonzero), `err` pulses once. Both enables are released and the block returns to idle, with no `done`. A line event arriving in the same cycle as expiry takes priority over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte is offered |
| cmd_ready | output | 1 | Block can take a command byte (idle) |
| cmd_data | input | 8 | Command byte |
| ps2_clk_in | input | 1 | Sensed level of the PS/2 clock line |
| ps2_dat_in | input | 1 | Sensed level of the PS/2 data line |
| clk_drive_low | output | 1 | 1 pulls the clock line low |
| dat_drive_low | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Frame in progress; hold off reception |
| done | output | 1 | One-cycle pulse: device acknowledged the frame |
| err | output | 1 | One-cycle pulse: a wait on the device timed out |

## Verification
The completion pulse and the acceptance of the next command can fall in the same cycle. Because `cmd_ready` rises in the very cycle `done` is high, a byte held on the port is taken on that edge. The bench provokes this by presenting a second byte partway through a frame and holding it. It judges the result by finding `cmd_ready` low throughout the first frame and high in the `done` cycle. It then expects `busy` high one cycle later, and a modelled device must receive both bytes intact and in order.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RTS,
    ST_START,
    ST_CLK_REL,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_REL_LO,
    ST_REL_HI,
    ST_ACK_DAT,
    ST_ACK_CLK
  } tx_state_e;

  function automatic logic odd_parity(input logic [7:0] d);
    return ~^d;
  endfunction

endpackage

// File: rtl/ps2_tx_sync.sv
module ps2_tx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/ps2_tx_timer.sv
module ps2_tx_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= value;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
  import ps2_tx_pkg::*;
#(
  parameter int HOLD_CYCLES    = 10000,
  parameter int TIMEOUT_CYCLES = 200000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_data,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic       clk_drive_low,
  output logic       dat_drive_low,
  output logic       busy,
  output logic       done,
  output logic       err
);

  localparam int  NBITS  = 9;
  localparam int  BIT_W  = $clog2(NBITS + 1);
  localparam int  MAXC   = (HOLD_CYCLES > TIMEOUT_CYCLES) ? HOLD_CYCLES : TIMEOUT_CYCLES;
  localparam int  CNT_W  = $clog2(MAXC + 1);
  localparam bit  TO_EN  = (TIMEOUT_CYCLES != 0);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] TO_LD   = TO_EN ? CNT_W'(TIMEOUT_CYCLES - 1) : '0;

  tx_state_e        state_q, state_d;
  logic [NBITS-1:0] shift_q, shift_d;
  logic [BIT_W-1:0] nbit_q, nbit_d;
  logic             dat_q, dat_d;
  logic             done_q, done_d, err_q, err_d;
  logic             clk_s, dat_s, tmr_zero, tmr_load, in_wait;
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] tmr_value;

  ps2_tx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ps2_clk_in, ps2_dat_in}), .q(sync_q)
  );
  assign clk_s = sync_q[1];
  assign dat_s = sync_q[0];

  assign tmr_load  = (state_d != state_q);
  assign tmr_value = (state_d == ST_RTS) ? HOLD_LD : TO_LD;

  ps2_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(tmr_value), .zero(tmr_zero)
  );

  assign in_wait = state_q inside {ST_CLK_REL, ST_BIT_LO, ST_BIT_HI, ST_REL_LO,
                                   ST_REL_HI, ST_ACK_DAT, ST_ACK_CLK};

  always_comb begin
    state_d = state_q;
    shift_d = shift_q;
    nbit_d  = nbit_q;
    dat_d   = dat_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_valid) begin
        shift_d = {odd_parity(cmd_data), cmd_data};
        nbit_d  = '0;
        state_d = ST_RTS;
      end
      ST_RTS: if (tmr_zero) begin
        dat_d   = 1'b1;
        state_d = ST_START;
      end
      ST_START:   state_d = ST_CLK_REL;
      ST_CLK_REL: if (clk_s) state_d = ST_BIT_LO;
      ST_BIT_LO: if (!clk_s) begin
        dat_d   = ~shift_q[0];
        shift_d = shift_q >> 1;
        state_d = ST_BIT_HI;
      end
      ST_BIT_HI: if (clk_s) begin
        nbit_d  = nbit_q + 1'b1;
        state_d = (nbit_q == BIT_W'(NBITS - 1)) ? ST_REL_LO : ST_BIT_LO;
      end
      ST_REL_LO: if (!clk_s) begin
        dat_d   = 1'b0;
        state_d = ST_REL_HI;
      end
      ST_REL_HI:  if (dat_s) state_d = ST_ACK_DAT;
      ST_ACK_DAT: if (!dat_s) state_d = ST_ACK_CLK;
      ST_ACK_CLK: if (!clk_s) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    // a line event in the expiry cycle wins over the timeout
    if (TO_EN && in_wait && tmr_zero && (state_d == state_q)) begin
      err_d   = 1'b1;
      dat_d   = 1'b0;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      nbit_q  <= '0;
      dat_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      shift_q <= shift_d;
      nbit_q  <= nbit_d;
      dat_q   <= dat_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign clk_drive_low = (state_q == ST_RTS) || (state_q == ST_START);
  assign dat_drive_low = dat_q;
  assign done          = done_q;
  assign err           = err_q;

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  p_start_after_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dat_drive_low) && state_q == ST_START) |-> $past(clk_drive_low));

  p_clk_free_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_CLK_REL, ST_BIT_LO, ST_BIT_HI, ST_REL_LO}) |-> !clk_drive_low);

  p_dat_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BIT_HI && $past(state_q) == ST_BIT_HI) |-> $stable(dat_drive_low));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cmd_ready && !clk_drive_low && !dat_drive_low));

  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_err_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !clk_drive_low && !dat_drive_low));

endmodule

// File: tb/ps2_cmd_tx_tb.sv
module ps2_cmd_tx_tb_top;

  localparam int HOLD = 50;
  localparam int TMO  = 300;
  localparam int SYNC = 2;
  localparam int H    = 20;
  localparam logic [8:0] VEC [0:5] = '{
    {1'b1, 8'hFF}, {1'b1, 8'h00}, {1'b1, 8'hED},
    {1'b0, 8'h01}, {1'b0, 8'hF4}, {1'b1, 8'hA5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = '0;
  logic dev_clk_low = 1'b0;
  logic dev_dat_low = 1'b0;
  logic cmd_ready, clk_drive_low, dat_drive_low, busy, done, err;
  logic ps2_clk_in, ps2_dat_in;

  always #5 clk = ~clk;

  assign ps2_clk_in = !(clk_drive_low || dev_clk_low);
  assign ps2_dat_in = !(dat_drive_low || dev_dat_low);

  ps2_cmd_tx #(.HOLD_CYCLES(HOLD), .TIMEOUT_CYCLES(TMO), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
    .clk_drive_low(clk_drive_low), .dat_drive_low(dat_drive_low),
    .busy(busy), .done(done), .err(err)
  );

  int checks = 0, fails = 0;
  int done_cnt = 0, err_cnt = 0;
  int hold_run = 0, last_hold = 0, both_run = 0, last_both = 0;

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (err)  err_cnt++;
    if (clk_drive_low && !dat_drive_low) hold_run++;
    else if (hold_run != 0) begin last_hold = hold_run; hold_run = 0; end
    if (clk_drive_low && dat_drive_low) both_run++;
    else if (both_run != 0) begin last_both = both_run; both_run = 0; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 busy after accept", busy, 1);
    chk("R2 ready low in frame", cmd_ready, 0);
  endtask

  // device model: clocks the frame, samples on the rising edge, optionally acks
  task automatic dev_run(input bit do_ack, output logic [7:0] b, output logic p,
                         output logic stop, output logic stable,
                         output logic early, output logic late);
    logic [8:0] bits;
    int c0;
    bits = '0; stable = 1'b1; early = 1'b0; late = 1'b0;
    @(negedge clk);
    while (!(dat_drive_low && !clk_drive_low)) @(negedge clk);
    repeat (H) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      dev_clk_low = 1'b1;
      repeat (H) @(negedge clk);
      bits[i] = ps2_dat_in;
      dev_clk_low = 1'b0;
      repeat (H) @(negedge clk);
      if (ps2_dat_in != bits[i]) stable = 1'b0;
    end
    dev_clk_low = 1'b1;
    repeat (H) @(negedge clk);
    stop = ps2_dat_in;
    dev_clk_low = 1'b0;
    repeat (H) @(negedge clk);
    if (do_ack) begin
      c0 = done_cnt;
      dev_dat_low = 1'b1;
      repeat (H) @(negedge clk);
      early = (done_cnt != c0);
      dev_clk_low = 1'b1;
      repeat (H) @(negedge clk);
      late = (done_cnt == c0 + 1);
      dev_clk_low = 1'b0;
      dev_dat_low = 1'b0;
      repeat (H) @(negedge clk);
    end
    b = bits[7:0];
    p = bits[8];
  endtask

  logic [7:0] rb, rb2;
  logic rp, rs, rst_ok, re, rl;
  logic rp2, rs2, rst2, re2, rl2;

  initial begin
    int n, e0, d0;
    repeat (5) @(negedge clk);
    chk("R1 ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready idle", cmd_ready, 1);
    chk("R1 busy idle", busy, 0);
    chk("R1 clk released", clk_drive_low, 0);
    chk("R1 dat released", dat_drive_low, 0);

    // vector table walk
    for (int i = 0; i < 6; i++) begin
      d0 = done_cnt;
      fork
        send(VEC[i][7:0]);
        dev_run(1'b1, rb, rp, rs, rst_ok, re, rl);
      join
      repeat (5) @(negedge clk);
      chk("R5 byte LSB first", rb, VEC[i][7:0]);
      chk("R6 odd parity", rp, VEC[i][8]);
      chk("R7 stop high", rs, 1);
      chk("R5 data stable on high clock", rst_ok, 1);
      chk("R8 no done before clock ack", re, 0);
      chk("R8 done after clock ack", rl, 1);
      chk("R8 single done", done_cnt - d0, 1);
      chk("R3 hold length", last_hold, HOLD);
      chk("R4 start overlap", last_both, 1);
      chk("R9 busy cleared", busy, 0);
      chk("R1 lines released", clk_drive_low + dat_drive_low, 0);
    end

    // held-off byte, then acceptance in the done cycle
    fork
      begin
        send(8'h3C);
        repeat (100) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = 8'hC3;
        @(negedge clk);
        chk("R2 ready low with valid", cmd_ready, 0);
        while (!done) @(negedge clk);
        chk("R8 ready in done cycle", cmd_ready, 1);
        @(negedge clk);
        chk("R2 taken at done edge", busy, 1);
        cmd_valid = 1'b0;
      end
      begin
        dev_run(1'b1, rb, rp, rs, rst_ok, re, rl);
        dev_run(1'b1, rb2, rp2, rs2, rst2, re2, rl2);
      end
    join
    repeat (5) @(negedge clk);
    chk("R2 first byte intact", rb, 8'h3C);
    chk("R2 second byte", rb2, 8'hC3);
    chk("R6 parity second", rp2, 1);
    chk("R8 second acked", rl2, 1);

    // no device response: timeout from the first wait after the clock is freed
    e0 = err_cnt; d0 = done_cnt;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = 8'h55;
    @(posedge clk);
    n = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!err && n < 3000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk("R10 timeout cycle", n, HOLD + TMO + SYNC + 2);
    chk("R10 busy dropped", busy, 0);
    chk("R10 lines released", clk_drive_low + dat_drive_low, 0);
    @(negedge clk);
    chk("R10 err single pulse", err_cnt - e0, 1);
    chk("R10 no done", done_cnt - d0, 0);

    // device clocks the frame but never acknowledges
    e0 = err_cnt; d0 = done_cnt;
    fork
      send(8'h5A);
      dev_run(1'b0, rb, rp, rs, rst_ok, re, rl);
    join
    n = 0;
    while (err_cnt == e0 && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk("R10 no-ack byte", rb, 8'h5A);
    chk("R10 no-ack err", err_cnt - e0, 1);
    chk("R10 no-ack no done", done_cnt - d0, 0);
    chk("R10 no-ack idle", busy, 0);
    chk("R10 no-ack dat released", dat_drive_low, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule